// File: doc/BRIEF.md
# Dual-Clock FIFO With Gray-Coded Pointers

This block moves a stream of data words from one clock domain to another whose clock may run at any frequency and phase relative to the first. The producer pushes words with a write enable on its own clock. The consumer pops them with a read enable on a second clock. A dual-port storage array sits between the two sides. It is written on the write clock and read on the read clock, and it is addressed as a ring that starts at entry 0 and wraps after the last entry.

Each side keeps a binary position counter and a registered Gray-coded copy of it. The Gray copy crosses into the other domain through a two-stage flop synchronizer. On the receiving side it is decoded back to binary and compared with that side's own counter, which produces a registered `full` or `empty` flag. A synchronized pointer may lag by a cycle, so both flags are deliberately pessimistic by one entry. `full` rises when DEPTH-1 words are held. `empty` stays high while at most one word is visible to the reader.

Top module: `afifo_gray`

## Requirements
- R1: While their resets are active and on the first cycle after release, `empty` is 1 and `full` is 0.
- R2: Words leave in exactly the order they were written, with no loss or duplication. This holds across ring wrap-around after 2^AW words.
- R3: `full` is 1 once the write side sees DEPTH-1 unread words. A write presented while `full` is 1 is ignored: it is not stored and it moves no pointer.
- R4: `empty` is 1 while the read side sees at most one unread word. A read presented while `empty` is 1 is ignored: `rd_data` keeps its value and no word is consumed.
- R5: The registered Gray pointer of each side changes in at most one bit per write-clock or read-clock cycle respectively.
- R6: After an accepted read, `rd_data` shows the popped word on the next read-clock cycle. Otherwise it holds its previous value.
- R7: R2 to R4 hold when the read clock is faster than, equal to or slower than the write clock.
- R8: Neither pointer ever overtakes the other. The write side never sees more than DEPTH-1 unread words, and the read side never sees more than DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Push request |
| wr_data | input | DW | Word to push |
| full | output | 1 | No more pushes accepted (registered) |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW | Popped word, valid one cycle after the pop |
| empty | output | 1 | No pops accepted (registered) |

## Verification
The bench first fills the FIFO with the reader stopped and keeps pushing marker words after `full` rises. This separates a correct DEPTH-1 limit from an off-by-one limit and from a write that leaks through while full. It then drains the FIFO and keeps popping while `empty` is high, which shows the one-word reserve and that stalled reads neither consume nor change data. Finally it runs gapped bursts of more than the depth with the read clock equal to, slower than and faster than the write clock. A scoreboard compares every popped word, so errors in pointer wrap, in Gray decoding or in flag timing at each ratio show up as ordering or integrity failures.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
  localparam int unsigned CODE_W = 32;

  // binary to reflected Gray code
  function automatic logic [CODE_W-1:0] to_gray(input logic [CODE_W-1:0] b);
    return (b >> 1) ^ b;
  endfunction

  // reflected Gray code to binary: bit k is the XOR of all bits at or above k
  function automatic logic [CODE_W-1:0] to_bin(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    for (int k = 0; k < CODE_W; k++) b[k] = ^(g >> k);
    return b;
  endfunction
endpackage

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
module afifo_mem #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/afifo_wside.sv
`timescale 1ns/1ps
module afifo_wside #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] rgray_s,
  output logic        full,
  output logic        wr_fire,
  output logic [AW:0] wbin,
  output logic [AW:0] wgray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH - 1);

  logic [PW-1:0] wbin_next, wgray_next, rbin_s, held_next, held_now;
  logic [afifo_pkg::CODE_W-1:0] g_wide, b_wide;

  always_comb begin
    wr_fire    = wr_en & ~full;
    wbin_next  = wbin + PW'(wr_fire);
    g_wide     = afifo_pkg::to_gray(afifo_pkg::CODE_W'(wbin_next));
    wgray_next = g_wide[PW-1:0];
    b_wide     = afifo_pkg::to_bin(afifo_pkg::CODE_W'(rgray_s));
    rbin_s     = b_wide[PW-1:0];
    held_next  = wbin_next - rbin_s;
    held_now   = wbin - rbin_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_next;
      wgray <= wgray_next;
      full  <= (held_next >= FULL_LVL);
    end
  end

  // R5: crossing pointer moves by one Gray step at most
  p_wgray_step_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R3: a push while full leaves the pointer where it was
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> (wgray == $past(wgray)));
  // R8: write side never holds more than DEPTH-1 unread words
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    held_now <= FULL_LVL);
endmodule

// File: rtl/afifo_rside.sv
`timescale 1ns/1ps
module afifo_rside #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  logic [AW:0] wgray_s,
  output logic        empty,
  output logic        rd_fire,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [PW-1:0] rbin_next, rgray_next, wbin_s, avail_next, avail_now;
  logic [afifo_pkg::CODE_W-1:0] g_wide, b_wide;

  always_comb begin
    rd_fire    = rd_en & ~empty;
    rbin_next  = rbin + PW'(rd_fire);
    g_wide     = afifo_pkg::to_gray(afifo_pkg::CODE_W'(rbin_next));
    rgray_next = g_wide[PW-1:0];
    b_wide     = afifo_pkg::to_bin(afifo_pkg::CODE_W'(wgray_s));
    wbin_s     = b_wide[PW-1:0];
    avail_next = wbin_s - rbin_next;
    avail_now  = wbin_s - rbin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_next;
      rgray <= rgray_next;
      empty <= (avail_next <= PW'(1));
    end
  end

  // R5: crossing pointer moves by one Gray step at most
  p_rgray_step_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R4: a pop while empty leaves the pointer where it was
  p_empty_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> (rgray == $past(rgray)));
  // R8: read pointer never runs past the synchronized write pointer
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    avail_now <= CAP);
endmodule

// File: rtl/afifo_gray.sv
`timescale 1ns/1ps
module afifo_gray #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int PW = AW + 1;

  logic          wr_fire, rd_fire;
  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;

  afifo_wside #(.AW(AW)) u_wside (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rgray_s(rgray_s),
    .full(full), .wr_fire(wr_fire), .wbin(wbin), .wgray(wgray)
  );

  afifo_rside #(.AW(AW)) u_rside (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wgray_s(wgray_s),
    .empty(empty), .rd_fire(rd_fire), .rbin(rbin), .rgray(rgray)
  );

  afifo_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  afifo_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  afifo_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wr_clk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .re(rd_fire), .raddr(rbin[AW-1:0]), .rdata(rd_data)
  );
endmodule

// File: tb/afifo_gray_tb_top.sv
`timescale 1ns/1ps
module afifo_gray_tb_top;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;

  realtime rd_half = 4.0;
  always #4.0 wr_clk = ~wr_clk;          // 125 MHz
  always #(rd_half) rd_clk = ~rd_clk;

  afifo_gray #(.AW(AW), .DW(DW)) dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] seq = 16'h0100;
  bit rd_active = 0, rd_force = 0, done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected words and compares one read-clock later
  initial begin
    bit pend = 0, have_last = 0;
    logic [DW-1:0] exp_d = '0, last = '0;
    forever begin
      @(negedge rd_clk);
      if (pend) begin
        check(rd_data === exp_d, "R2/R6 data order", 32'(rd_data), 32'(exp_d));
        last = rd_data; have_last = 1;
      end else if (have_last) begin
        check(rd_data === last, "R6/R4 hold", 32'(rd_data), 32'(last));
      end
      if (!rd_rst && rd_active && !empty && sb.size() > 0) begin
        rd_en = 1; exp_d = sb.pop_front(); pend = 1;
      end else begin
        rd_en = rd_force; pend = 0;
      end
    end
  end

  task automatic push_items(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      while (full) begin wr_en = 0; @(negedge wr_clk); end
      wr_en = 1; wr_data = seq; sb.push_back(seq); seq++;
      if (gap > 0) begin
        @(negedge wr_clk); wr_en = 0;
        repeat ($urandom % gap) @(negedge wr_clk);
      end
    end
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while (sb.size() > 1 && t < 4000) begin @(negedge wr_clk); t++; end
    repeat (30) @(negedge wr_clk);
    check(sb.size() == 1, req, 32'(sb.size()), 32'd1);
    check(empty == 1'b1, req, 32'(empty), 32'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int accepted = 0;
    repeat (4) @(negedge wr_clk);
    check(empty == 1'b1, "R1 empty in reset", 32'(empty), 32'd1);
    check(full == 1'b0, "R1 full in reset", 32'(full), 32'd0);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    @(negedge wr_clk);
    check(empty == 1'b1, "R1 empty after release", 32'(empty), 32'd1);
    check(full == 1'b0, "R1 full after release", 32'(full), 32'd0);

    // R3: fill with reader stopped, keep pushing markers while full
    for (int i = 0; i < DEPTH + 6; i++) begin
      @(negedge wr_clk);
      wr_en = 1;
      if (!full) begin
        wr_data = seq; sb.push_back(seq); seq++; accepted++;
      end else begin
        wr_data = 16'hBAD0;
      end
    end
    @(negedge wr_clk); wr_en = 0;
    check(accepted == DEPTH - 1, "R3 words accepted before full",
          32'(accepted), 32'(DEPTH - 1));
    check(full == 1'b1, "R3 full held", 32'(full), 32'd1);

    // R4: drain; one word stays in reserve behind empty
    rd_active = 1;
    wait_drain("R4 one-word reserve after drain");
    check(full == 1'b0, "R3 full cleared after drain", 32'(full), 32'd0);

    // R4: pops while empty are ignored (monitor checks rd_data holds)
    rd_force = 1;
    repeat (10) @(negedge rd_clk);
    rd_force = 0;
    check(sb.size() == 1, "R4 stalled pops consume nothing", 32'(sb.size()), 32'd1);
    push_items(1, 0);
    wait_drain("R4 leftover word released by next write");

    // R7: bursts at equal, slower and faster read clocks (wraps the ring, R2)
    rd_half = 4.0;
    push_items(60, 3);
    wait_drain("R7 equal clocks");
    rd_half = 11.0;
    push_items(60, 0);
    wait_drain("R7 slow read clock");
    rd_half = 1.7;
    push_items(60, 4);
    wait_drain("R7 fast read clock");
    rd_half = 6.5;
    push_items(40, 0);
    wait_drain("R7 mid ratio back-to-back");

    done = 1;
    finish_run();
  end
endmodule